// File: doc/BRIEF.md
# Split-Byte Sampling Converter Sequencer

This block sits on the host side of a 16-bit successive-approximation converter whose result comes out on an 8-bit bus in two halves. It drives the converter's active-low read/convert and chip-select strobes and a byte-swap select. It watches the converter's busy line and collects the two bytes. It then presents the assembled word to the rest of the chip through a valid/ready pair. All analog timing limits are given in nanoseconds as parameters. They are rounded up to whole system-clock cycles, so one netlist can serve any clock rate.

Two start protocols are available through `cs_mode`. In strobe mode the chip select stays asserted the whole time, and a low pulse on read/convert alone launches a conversion. In select mode, read/convert is lowered first. A chip-select pulse then launches the conversion, and a second chip-select assertion with read/convert high reads the result. A format input can invert the result's top bit, which converts between offset binary and two's complement. A watchdog on the busy line reports a conversion that never completes.

Top module: `adc_byte_reader`

## Requirements
- R1: During and right after reset, `adc_rc_n` is 1, `adc_byte` is 0, `out_valid` is 0 and `conv_timeout` is 0. With `cs_mode` at 0, `adc_cs_n` is 0.
- R2: The conversion-launch low pulse keeps `adc_rc_n` low for PULSE_CYC cycles in strobe mode and for SETUP_CYC+PULSE_CYC cycles in select mode. It always returns high before RETURN_CYC cycles have passed.
- R3: In strobe mode (`cs_mode`=0), `adc_cs_n` is held at 0 on every cycle.
- R4: In select mode (`cs_mode`=1), `adc_rc_n` falls exactly SETUP_CYC cycles before `adc_cs_n` falls. The two strobes rise on the same cycle. For readback, `adc_cs_n` is lowered again while `adc_rc_n` stays high.
- R5: After busy has been seen low and then high, the upper byte is read with `adc_byte`=0 and the lower byte with `adc_byte`=1, in that order. Each byte is sampled only after its select pattern has been steady for ACCESS_CYC cycles.
- R6: `out_data` equals {upper byte, lower byte} when `fmt_flip`=0. When `fmt_flip`=1, bit 15 of that word is inverted.
- R7: While `out_valid`=1 and `out_ready`=0, `out_valid` and `out_data` hold. A word leaves on a cycle with both high. No conversion is launched while `out_valid`=1.
- R8: Two conversion launches (both strobes low together) are at least SPACING_CYC cycles apart.
- R9: If busy has not completed its low-then-high cycle within TIMEOUT_CYC cycles of the launch, `conv_timeout` goes to 1 exactly TIMEOUT_CYC cycles after the launch. The sequencer returns to idle with no word emitted, and `conv_timeout` clears at the next launch.
- R10: With `start_req`=0, no conversion is launched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_req | input | 1 | Conversion request, level sensitive |
| cs_mode | input | 1 | 0: strobe mode, 1: select mode; sampled while idle |
| fmt_flip | input | 1 | 1 inverts result bit 15 |
| adc_busy | input | 1 | Converter busy, low while converting |
| adc_data | input | 8 | Converter byte bus |
| adc_rc_n | output | 1 | Read/convert strobe, active low converts |
| adc_cs_n | output | 1 | Chip select, active low |
| adc_byte | output | 1 | 0 selects upper byte, 1 lower byte |
| out_valid | output | 1 | Result word available |
| out_ready | input | 1 | Consumer accepts the word |
| out_data | output | 16 | Assembled result |
| conv_timeout | output | 1 | Busy watchdog expired on the last conversion |

## Verification
The bench's converter model drives the inverted byte until a select pattern has been steady for the access delay. A sequencer that samples one cycle early therefore produces a corrupted word. A swapped byte order or an ignored format bit shows up as a miscompare against the expected word. Pulse lengths, the select-mode setup gap and launch spacing are measured at the pins. A short pulse, a cs falling together with rc, or a start that ignores the spacing counter each produce a wrong count. A converter that never raises busy checks that the watchdog fires on the exact cycle, that no word appears, and that the flag clears on the next launch. Long consumer stalls check that an unread word is neither overwritten nor followed by a new launch.

// File: rtl/adc_byte_reader.sv
module adc_byte_reader #(
  parameter int CLK_NS     = 10,
  parameter int PULSE_NS   = 40,
  parameter int SETUP_NS   = 10,
  parameter int ACCESS_NS  = 83,
  parameter int RETURN_NS  = 3000,
  parameter int SPACING_NS = 10000,
  parameter int TIMEOUT_NS = 12000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start_req,
  input  logic        cs_mode,
  input  logic        fmt_flip,
  input  logic        adc_busy,
  input  logic [7:0]  adc_data,
  output logic        adc_rc_n,
  output logic        adc_cs_n,
  output logic        adc_byte,
  output logic        out_valid,
  input  logic        out_ready,
  output logic [15:0] out_data,
  output logic        conv_timeout
);

  function automatic int cyc(input int ns);
    int c;
    c = (ns + CLK_NS - 1) / CLK_NS;
    return (c < 1) ? 1 : c;
  endfunction

  localparam int PULSE_CYC   = cyc(PULSE_NS);
  localparam int SETUP_CYC   = cyc(SETUP_NS);
  localparam int ACCESS_CYC  = cyc(ACCESS_NS);
  localparam int RETURN_CYC  = cyc(RETURN_NS);
  localparam int SPACING_CYC = cyc(SPACING_NS);
  localparam int TIMEOUT_CYC = cyc(TIMEOUT_NS);
  localparam int MAXC = (PULSE_CYC > SETUP_CYC)
                      ? ((PULSE_CYC > ACCESS_CYC) ? PULSE_CYC : ACCESS_CYC)
                      : ((SETUP_CYC > ACCESS_CYC) ? SETUP_CYC : ACCESS_CYC);
  localparam int CW = $clog2(MAXC + 1);
  localparam int SW = $clog2(SPACING_CYC + 1);
  localparam int TW = $clog2(TIMEOUT_CYC + 1);
  localparam int RW = $clog2(RETURN_CYC + 2);

  typedef enum logic [2:0] {S_IDLE, S_SETUP, S_PULSE, S_WAIT, S_RDHI, S_RDLO} state_t;

  state_t        state;
  logic [CW-1:0] cnt;
  logic [SW-1:0] space;
  logic [TW-1:0] tcnt;
  logic          busy_s1, busy_s2, seen_low, mode_q;
  logic [7:0]    hi_q;

  wire go       = start_req && !out_valid && (space == '0);
  wire cnt_done_setup  = (cnt == CW'(SETUP_CYC - 1));
  wire cnt_done_pulse  = (cnt == CW'(PULSE_CYC - 1));
  wire cnt_done_access = (cnt == CW'(ACCESS_CYC - 1));

  assign adc_rc_n = !(state == S_SETUP || state == S_PULSE);
  assign adc_cs_n = mode_q ? !(state == S_PULSE || state == S_RDHI || state == S_RDLO) : 1'b0;
  assign adc_byte = (state == S_RDLO);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_s1 <= 1'b1;
      busy_s2 <= 1'b1;
    end else begin
      busy_s1 <= adc_busy;
      busy_s2 <= busy_s1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state        <= S_IDLE;
      cnt          <= '0;
      space        <= '0;
      tcnt         <= '0;
      seen_low     <= 1'b0;
      mode_q       <= 1'b0;
      hi_q         <= '0;
      out_valid    <= 1'b0;
      out_data     <= '0;
      conv_timeout <= 1'b0;
    end else begin
      if (space != '0) space <= space - 1'b1;
      if (out_valid && out_ready) out_valid <= 1'b0;
      unique case (state)
        S_IDLE: begin
          mode_q <= cs_mode;
          cnt    <= '0;
          if (go) begin
            if (cs_mode) begin
              state <= S_SETUP;
            end else begin
              state        <= S_PULSE;
              space        <= SW'(SPACING_CYC - 1);
              tcnt         <= '0;
              seen_low     <= 1'b0;
              conv_timeout <= 1'b0;
            end
          end
        end
        S_SETUP: begin
          if (cnt_done_setup) begin
            state        <= S_PULSE;
            cnt          <= '0;
            space        <= SW'(SPACING_CYC - 1);
            tcnt         <= '0;
            seen_low     <= 1'b0;
            conv_timeout <= 1'b0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_PULSE: begin
          tcnt <= tcnt + 1'b1;
          if (cnt_done_pulse) begin
            state <= S_WAIT;
            cnt   <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_WAIT: begin
          tcnt <= tcnt + 1'b1;
          if (!busy_s2) seen_low <= 1'b1;
          if (seen_low && busy_s2) begin
            state <= S_RDHI;
            cnt   <= '0;
          end else if (tcnt == TW'(TIMEOUT_CYC - 1)) begin
            state        <= S_IDLE;
            conv_timeout <= 1'b1;
          end
        end
        S_RDHI: begin
          if (cnt_done_access) begin
            hi_q  <= adc_data;
            state <= S_RDLO;
            cnt   <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_RDLO: begin
          if (cnt_done_access) begin
            out_data  <= {hi_q, adc_data} ^ {fmt_flip, 15'd0};
            out_valid <= 1'b1;
            state     <= S_IDLE;
            cnt       <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  logic [RW-1:0] lowrun;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lowrun <= '0;
    else if (adc_rc_n) lowrun <= '0;
    else if (lowrun != RW'(RETURN_CYC + 1)) lowrun <= lowrun + 1'b1;
  end

  assert_pulse_width_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(adc_rc_n) |-> lowrun >= RW'(PULSE_CYC));

  assert_return_deadline_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !adc_rc_n |-> lowrun < RW'(RETURN_CYC));

  assert_cs_setup_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q && $fell(adc_cs_n) && !adc_rc_n) |-> lowrun >= RW'(SETUP_CYC));

  assert_byte_order_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(adc_byte) |-> (!adc_cs_n && adc_rc_n));

  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  assert_no_start_pending_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(adc_rc_n) |-> !out_valid);

  assert_timeout_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(conv_timeout) |-> (adc_rc_n && !adc_byte && !out_valid));

endmodule

// File: tb/adc_byte_reader_bench.sv
module adc_byte_reader_bench;
  localparam int P_PULSE = 4, P_SETUP = 1, P_ACCESS = 9, P_SPACING = 1000, P_TIMEOUT = 1200;
  localparam int CONV = 60;

  logic clk = 0, rst_n = 0, start_req = 0, cs_mode = 0, fmt_flip = 0, adc_busy = 1, out_ready = 0;
  logic [7:0] adc_data = 8'h00;
  logic adc_rc_n, adc_cs_n, adc_byte, out_valid, conv_timeout;
  logic [15:0] out_data;

  always #5 clk = ~clk;

  adc_byte_reader u_adc_byte_reader (
    .clk(clk), .rst_n(rst_n), .start_req(start_req), .cs_mode(cs_mode), .fmt_flip(fmt_flip),
    .adc_busy(adc_busy), .adc_data(adc_data), .adc_rc_n(adc_rc_n), .adc_cs_n(adc_cs_n),
    .adc_byte(adc_byte), .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .conv_timeout(conv_timeout));

  int checks = 0, fails = 0, starts = 0, pops = 0, nconv = 0, stall = 0, hold_cnt = 0;
  int rc_run = 0, gap = 0, t_since = 0, age = 0, conv_left = 0;
  bit have_start = 0, converting = 0, hang_req = 0, hang_this = 0, done = 0, timeouts = 0;
  bit prev_both = 0, prev_cs = 0, prev_rc = 1, prev_err = 0, prev_mode = 0, monitor = 0;
  logic [2:0] sel_prev = 3'b000;
  logic [15:0] result = 16'h0, held = 16'h0;
  logic [15:0] expq[$];

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [15:0] sample(input int n);
    case (n)
      0: return 16'h0000;
      1: return 16'hFFFF;
      2: return 16'h8000;
      3: return 16'h7FFF;
      default: return 16'(n * 40503 + 4660);
    endcase
  endfunction

  always @(negedge clk) begin
    bit both, start_now;
    logic [2:0] sel;
    if (monitor) begin
      both = !adc_cs_n && !adc_rc_n;
      start_now = both && !prev_both;
      // R3: strobe mode keeps chip select asserted
      if (!cs_mode && !prev_mode) check(adc_cs_n == 1'b0, "R3", adc_cs_n, 0);
      // R4: select mode, rc leads cs by the setup gap
      if (cs_mode && prev_cs && !adc_cs_n && !adc_rc_n) check(rc_run == P_SETUP, "R4", rc_run, P_SETUP);
      if (adc_rc_n && !prev_rc) begin
        // R2: pulse length
        check(rc_run == (cs_mode ? P_SETUP + P_PULSE : P_PULSE), "R2", rc_run,
              cs_mode ? P_SETUP + P_PULSE : P_PULSE);
        // R4: both strobes rise together in select mode
        if (cs_mode) check(adc_cs_n && !prev_cs, "R4", {prev_cs, adc_cs_n}, 2'b01);
      end
      rc_run = adc_rc_n ? 0 : rc_run + 1;
      if (start_now) begin
        starts++;
        // R8: launch spacing
        if (have_start) check(gap >= P_SPACING, "R8", gap, P_SPACING);
        // R7: no launch with unread word; R9: flag clears on launch
        check(!out_valid, "R7", out_valid, 0);
        check(!conv_timeout, "R9", conv_timeout, 0);
        have_start = 1; gap = 1; t_since = 0;
        converting = 1; conv_left = CONV; adc_busy = 0;
        hang_this = hang_req; hang_req = 0;
      end else begin
        gap++; t_since++;
        if (converting && !hang_this) begin
          conv_left--;
          if (conv_left == 0) begin
            converting = 0;
            result = sample(nconv);
            expq.push_back(result ^ {fmt_flip, 15'd0});
            nconv++;
            adc_busy = 1;
            age = 0;
          end
        end
      end
      if (conv_timeout && !prev_err) begin
        timeouts = 1;
        // R9: exact watchdog cycle, sequencer idle
        check(t_since == P_TIMEOUT, "R9", t_since, P_TIMEOUT);
        check(adc_rc_n && !out_valid, "R9", {adc_rc_n, out_valid}, 2'b10);
      end
      sel = {adc_cs_n, adc_rc_n, adc_byte};
      if (sel != sel_prev) age = 1; else age++;
      sel_prev = sel;
      // R5: bus carries the wrong byte until the access delay has elapsed
      if (!adc_cs_n && adc_rc_n && age >= P_ACCESS)
        adc_data = adc_byte ? result[7:0] : result[15:8];
      else
        adc_data = adc_byte ? ~result[7:0] : ~result[15:8];
      if (out_ready) begin
        out_ready = 0;
        // R7: word leaves after acceptance
        check(!out_valid, "R7", out_valid, 0);
      end else if (out_valid) begin
        if (hold_cnt > 0) check(out_data == held, "R7", out_data, held);
        held = out_data;
        if (hold_cnt >= stall) begin
          // R5 R6: assembled word and format
          check(expq.size() > 0 && out_data == expq[0], "R6", out_data,
                expq.size() > 0 ? expq[0] : 16'hDEAD);
          if (expq.size() > 0) void'(expq.pop_front());
          pops++;
          out_ready = 1;
          hold_cnt = 0;
        end else hold_cnt++;
      end
      prev_both = both; prev_cs = adc_cs_n; prev_rc = adc_rc_n;
      prev_err = conv_timeout; prev_mode = cs_mode;
    end
  end

  task automatic run_words(input int n);
    int target = pops + n;
    start_req = 1;
    while (pops < target) @(posedge clk);
    start_req = 0;
    repeat (20) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check(adc_rc_n == 1 && adc_byte == 0 && out_valid == 0 && conv_timeout == 0 && adc_cs_n == 0,
          "R1", {adc_rc_n, adc_byte, out_valid, conv_timeout, adc_cs_n}, 5'b10000);
    rst_n = 1;
    repeat (2) @(negedge clk);
    check(adc_rc_n == 1 && adc_byte == 0 && out_valid == 0 && conv_timeout == 0 && adc_cs_n == 0,
          "R1", {adc_rc_n, adc_byte, out_valid, conv_timeout, adc_cs_n}, 5'b10000);
    monitor = 1;
    repeat (2500) @(negedge clk);
    check(starts == 0, "R10", starts, 0);
    stall = 0;  fmt_flip = 0; run_words(4);
    stall = 37; fmt_flip = 1; run_words(3);
    cs_mode = 1; repeat (5) @(negedge clk);
    stall = 5;  fmt_flip = 0; run_words(3);
    stall = 0;  fmt_flip = 1; run_words(3);
    cs_mode = 0; repeat (5) @(negedge clk);
    hang_req = 1; start_req = 1;
    while (!timeouts) @(posedge clk);
    check(pops == 13 && expq.size() == 0, "R9", pops, 13);
    run_words(2);
    check(starts == 16, "R8", starts, 16);
    check(expq.size() == 0, "R6", expq.size(), 0);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired (all requirements) actual=%0d expected=%0d", pops, 15);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule